// File: doc/BRIEF.md
# Serial Bit-Rate Clock Generator

This block produces the timing strobes that a serial transmitter and receiver need. A reloadable down-counter divides the system clock by a programmable amount and marks each wrap with a one-cycle base tick. A small prescaler then turns the base tick into a per-bit transmit strobe and a receive strobe that suit the selected clocking mode. The block also drives a transfer-clock pin when it is the clock master, and synchronizes and edge-detects that pin when another device supplies the clock.

Four clocking modes come from three control bits. A synchronous-select bit picks asynchronous or synchronous operation. In asynchronous operation, a speed bit chooses 16x or 8x oversampling. In synchronous operation, the speed bit has no effect, and the pin-direction bit chooses between an internally generated clock and an external one. Writing a new divisor restarts the count at once, so a rate change does not wait for the old interval to run out.

Top module: `baud_clkgen`

## Requirements
- R1: While `rst_n` is low, `tx_tick_o`, `rx_tick_o`, `xfer_clk_o`, `ext_rise_o` and `ext_fall_o` are all 0.
- R2: With a divisor D held, the base tick recurs every D+1 cycles. In asynchronous mode, `rx_tick_o` equals the base tick. D = 0 gives a tick on every cycle.
- R3: A cycle with `div_wr_i` high loads `div_i` straight into the counter and gives no tick. The first base tick after the write falls D+1 cycles later, whatever the old count was.
- R4: Asynchronous mode (`sync_sel_i`=0) with `dbl_speed_i`=0 gives one `tx_tick_o` every 16 base ticks, so the period is 16(D+1) cycles. Each `tx_tick_o` coincides with an `rx_tick_o`.
- R5: Asynchronous mode with `dbl_speed_i`=1 gives one `tx_tick_o` every 8 base ticks, so the period is 8(D+1) cycles.
- R6: Synchronous master mode (`sync_sel_i`=1, `clk_dir_out_i`=1) sets `xfer_clk_oe_o`=1. `xfer_clk_o` toggles on each base tick, so its period is 2(D+1). `tx_tick_o` marks the cycle before the clock falls, when `xfer_clk_o`=1. `rx_tick_o` marks the cycle before it rises, when `xfer_clk_o`=0. `tx_tick_o` recurs every 2(D+1) cycles.
- R7: In synchronous mode, `dbl_speed_i` has no effect: the master `tx_tick_o` period stays 2(D+1).
- R8: In asynchronous mode, `xfer_clk_oe_o` and `xfer_clk_o` are 0, and toggling `xfer_clk_pin_i` produces no `ext_rise_o` or `ext_fall_o`.
- R9: Synchronous slave mode (`sync_sel_i`=1, `clk_dir_out_i`=0) sets `xfer_clk_oe_o`=0 and `xfer_clk_o`=0. `rx_tick_o` follows `ext_rise_o` and `tx_tick_o` follows `ext_fall_o`.
- R10: In slave mode, a pin level change set up before clock edge k produces a single-cycle edge pulse in the cycle between edges k+1 and k+2. The pulse comes through two synchronizer flops and one history flop. A rise and a fall are never flagged together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | 12 | Divisor value, period = value+1 cycles |
| div_wr_i | input | 1 | Load strobe for `div_i`; restarts the count |
| sync_sel_i | input | 1 | 0 asynchronous, 1 synchronous |
| dbl_speed_i | input | 1 | 8x oversampling in asynchronous mode |
| clk_dir_out_i | input | 1 | Pin direction in synchronous mode: 1 master, 0 slave |
| xfer_clk_pin_i | input | 1 | External transfer clock from the pin |
| tx_tick_o | output | 1 | Per-bit transmit strobe |
| rx_tick_o | output | 1 | Receive sample strobe |
| xfer_clk_o | output | 1 | Generated transfer clock (master) |
| xfer_clk_oe_o | output | 1 | Output enable for the transfer-clock pin |
| ext_rise_o | output | 1 | Rising edge of the synchronized external clock |
| ext_fall_o | output | 1 | Falling edge of the synchronized external clock |

## Verification
Strobe intervals are measured for several divisors, including 0, in each of the four modes. This separates the ÷16, ÷8 and ÷2 ratios and shows that the speed bit is ignored in synchronous mode. A divisor write made partway through a long count shows whether the reload happens at once or waits for the old count to finish. The external pin is toggled in asynchronous mode and in slave mode, at cycle-exact points. This tells apart the gating of the sampler, the synchronizer latency and the single-cycle width of the rise and fall pulses.

// File: rtl/baud_clk_pkg.sv
// Package: shared types and helpers for the bit-rate clock generator.
// Assumes: the three control bits are static for a whole frame.
package baud_clk_pkg;

    typedef enum logic [1:0] {
        CM_ASYNC_X16 = 2'd0,
        CM_ASYNC_X8  = 2'd1,
        CM_SYNC_INT  = 2'd2,
        CM_SYNC_EXT  = 2'd3
    } clk_mode_e;

    // Fold the three control bits into one mode; the speed bit only matters when asynchronous.
    function automatic clk_mode_e decode_mode(input logic sync_sel,
                                              input logic dbl,
                                              input logic dir_out);
        clk_mode_e m;
        if (!sync_sel) begin
            m = dbl ? CM_ASYNC_X8 : CM_ASYNC_X16;
        end else begin
            m = dir_out ? CM_SYNC_INT : CM_SYNC_EXT;
        end
        return m;
    endfunction

endpackage

// File: rtl/baud_divider.sv
// Module: reloadable down-counter that emits one base tick per wrap.
// Assumes: a write strobe overrides the count in the same cycle; the
// tick is suppressed in that cycle and while reset is held.
module baud_divider #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             div_wr_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    // Wrap point: counter at zero and no write pending.
    assign wrap   = (cnt_q == '0) && !div_wr_i;
    assign tick_o = wrap && rst_n;

    // Holds the programmed divisor.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (div_wr_i) div_q <= div_i;
    end

    // Counts down, reloading on a write or at the wrap point.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (div_wr_i) cnt_q <= div_i;
        else if (wrap)     cnt_q <= div_q;
        else               cnt_q <= cnt_q - 1'b1;
    end

    // R3
    reload_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr_i |=> cnt_q == $past(div_i));

    // R2
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> cnt_q == div_q);

    // R3
    no_tick_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr_i |-> !tick_o);

endmodule

// File: rtl/ext_clk_sync.sv
// Module: synchronizer chain and edge detector for the external transfer clock.
// Assumes: the pin is asynchronous to clk; edges are reported only when
// enabled (slave mode), but the chain keeps sampling so its history stays current.
module ext_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] chain_q;
    logic            cur;
    logic            prev;

    // First flop samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin_i;
    end

    // Remaining synchronizer stages and one history flop.
    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign cur    = chain_q[STAGES-1];
    assign prev   = chain_q[STAGES];
    // Edge pulses, gated by the enable and reset.
    assign rise_o = en_i && rst_n && cur && !prev;
    assign fall_o = en_i && rst_n && !cur && prev;

    // R10
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));

    // R10
    rise_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o && en_i) |=> !rise_o);

    // R10
    fall_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o && en_i) |=> !fall_o);

endmodule

// File: rtl/rate_prescaler.sv
// Module: turns the base tick into per-mode transmit and receive strobes
// and the master transfer clock.
// Assumes: the base tick is a one-cycle pulse; the edge inputs are already
// synchronized and only pulse in slave mode.
module rate_prescaler
    import baud_clk_pkg::*;
#(
    parameter int NORM_RATIO = 16,
    parameter int DBL_RATIO  = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      base_tick_i,
    input  clk_mode_e mode_i,
    input  logic      ext_rise_i,
    input  logic      ext_fall_i,
    output logic      tx_tick_o,
    output logic      rx_tick_o,
    output logic      xclk_o
);
    localparam int PRE_W = $clog2(NORM_RATIO);
    localparam logic [PRE_W-1:0] NORM_MASK = PRE_W'(NORM_RATIO - 1);
    localparam logic [PRE_W-1:0] DBL_MASK  = PRE_W'(DBL_RATIO - 1);
    localparam logic [PRE_W-1:0] SYNC_MASK = PRE_W'(1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             at_top;

    // Phase counter advances on every base tick while the clock is internal.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 pre_q <= '0;
        else if (base_tick_i && mode_i != CM_SYNC_EXT) pre_q <= pre_q + 1'b1;
    end

    // Select the division mask for the active mode.
    always_comb begin
        unique case (mode_i)
            CM_ASYNC_X16: mask = NORM_MASK;
            CM_ASYNC_X8:  mask = DBL_MASK;
            default:      mask = SYNC_MASK;
        endcase
    end

    assign at_top = (pre_q & mask) == mask;

    // Route the strobes by mode.
    always_comb begin
        tx_tick_o = 1'b0;
        rx_tick_o = 1'b0;
        xclk_o    = 1'b0;
        unique case (mode_i)
            CM_ASYNC_X16, CM_ASYNC_X8: begin
                tx_tick_o = base_tick_i && at_top;
                rx_tick_o = base_tick_i;
            end
            CM_SYNC_INT: begin
                xclk_o    = pre_q[0];
                tx_tick_o = base_tick_i && pre_q[0];
                rx_tick_o = base_tick_i && !pre_q[0];
            end
            default: begin
                tx_tick_o = ext_fall_i;
                rx_tick_o = ext_rise_i;
            end
        endcase
    end

    // R4
    tx_on_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i inside {CM_ASYNC_X16, CM_ASYNC_X8} && tx_tick_o) |-> rx_tick_o);

    // R6
    master_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CM_SYNC_INT && tx_tick_o) |-> xclk_o);

endmodule

// File: rtl/baud_clkgen.sv
// Module: top of the bit-rate clock generator. Combines the divider, the
// prescaler and the external-clock synchronizer for four clocking modes.
// Assumes: control bits change only between frames; synchronous reset.
module baud_clkgen
    import baud_clk_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int NORM_RATIO  = 16,
    parameter int DBL_RATIO   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             div_wr_i,
    input  logic             sync_sel_i,
    input  logic             dbl_speed_i,
    input  logic             clk_dir_out_i,
    input  logic             xfer_clk_pin_i,
    output logic             tx_tick_o,
    output logic             rx_tick_o,
    output logic             xfer_clk_o,
    output logic             xfer_clk_oe_o,
    output logic             ext_rise_o,
    output logic             ext_fall_o
);
    clk_mode_e mode;
    logic      base_tick;
    logic      slave_en;
    logic      xclk_raw;

    // Mode decode and pin direction.
    assign mode          = decode_mode(sync_sel_i, dbl_speed_i, clk_dir_out_i);
    assign slave_en      = (mode == CM_SYNC_EXT);
    assign xfer_clk_oe_o = (mode == CM_SYNC_INT);
    assign xfer_clk_o    = xclk_raw && rst_n;

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_i    (div_i),
        .div_wr_i (div_wr_i),
        .tick_o   (base_tick)
    );

    ext_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (slave_en),
        .pin_i  (xfer_clk_pin_i),
        .rise_o (ext_rise_o),
        .fall_o (ext_fall_o)
    );

    rate_prescaler #(.NORM_RATIO(NORM_RATIO), .DBL_RATIO(DBL_RATIO)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_tick_i (base_tick),
        .mode_i      (mode),
        .ext_rise_i  (ext_rise_o),
        .ext_fall_i  (ext_fall_o),
        .tx_tick_o   (tx_tick_o),
        .rx_tick_o   (rx_tick_o),
        .xclk_o      (xclk_raw)
    );

    // R8
    async_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_sel_i |-> (!ext_rise_o && !ext_fall_o && !xfer_clk_o));

    // R9
    slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_sel_i && !clk_dir_out_i) |-> (rx_tick_o == ext_rise_o && tx_tick_o == ext_fall_o));

    // R6
    master_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_sel_i && clk_dir_out_i && $past(sync_sel_i && clk_dir_out_i)
         && xfer_clk_o != $past(xfer_clk_o)) |-> $past(tx_tick_o || rx_tick_o));

endmodule

// File: tb/baud_clkgen_tb_top.sv
module baud_clkgen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] div_i = '0;
    logic        div_wr_i = 1'b0;
    logic        sync_sel_i = 1'b0;
    logic        dbl_speed_i = 1'b0;
    logic        clk_dir_out_i = 1'b0;
    logic        xfer_clk_pin_i = 1'b0;
    logic        tx_tick_o, rx_tick_o, xfer_clk_o, xfer_clk_oe_o, ext_rise_o, ext_fall_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    baud_clkgen dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .div_i          (div_i),
        .div_wr_i       (div_wr_i),
        .sync_sel_i     (sync_sel_i),
        .dbl_speed_i    (dbl_speed_i),
        .clk_dir_out_i  (clk_dir_out_i),
        .xfer_clk_pin_i (xfer_clk_pin_i),
        .tx_tick_o      (tx_tick_o),
        .rx_tick_o      (rx_tick_o),
        .xfer_clk_o     (xfer_clk_o),
        .xfer_clk_oe_o  (xfer_clk_oe_o),
        .ext_rise_o     (ext_rise_o),
        .ext_fall_o     (ext_fall_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Program a divisor at a negedge; the write is one cycle long.
    task automatic write_div(input int d);
        @(negedge clk);
        div_i    = 12'(d);
        div_wr_i = 1'b1;
        @(negedge clk);
        div_wr_i = 1'b0;
    endtask

    // Interval between two consecutive strobes: sel 0 = tx, 1 = rx.
    task automatic measure(input int sel, output int n);
        int guard = 0;
        n = 0;
        while (!((sel == 0) ? tx_tick_o : rx_tick_o) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        do begin
            @(negedge clk);
            n++;
        end while (!((sel == 0) ? tx_tick_o : rx_tick_o) && n < 5000);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 outputs in reset", {tx_tick_o, rx_tick_o, xfer_clk_o, ext_rise_o, ext_fall_o}, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_div_period();
        int n;
        sync_sel_i = 1'b0; dbl_speed_i = 1'b0;
        write_div(4);
        measure(1, n); chk("R2 rx period D=4", n, 5);
        write_div(0);
        measure(1, n); chk("R2 rx period D=0", n, 1);
        write_div(9);
        measure(1, n); chk("R2 rx period D=9", n, 10);
    endtask

    task automatic t_div_reload();
        int n = 1;
        write_div(200);
        repeat (30) @(negedge clk);
        div_i = 12'd5; div_wr_i = 1'b1;
        #1;
        chk("R3 no tick on write cycle", rx_tick_o, 0);
        @(negedge clk);
        div_wr_i = 1'b0;
        while (!rx_tick_o && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R3 first tick after write", n, 6);
    endtask

    task automatic t_async_norm();
        int n;
        sync_sel_i = 1'b0; dbl_speed_i = 1'b0;
        write_div(3);
        measure(0, n); measure(0, n); chk("R4 tx period x16 D=3", n, 64);
        chk("R4 rx with tx", rx_tick_o, 1);
        write_div(0);
        measure(0, n); measure(0, n); chk("R4 tx period x16 D=0", n, 16);
    endtask

    task automatic t_async_dbl();
        int n;
        sync_sel_i = 1'b0; dbl_speed_i = 1'b1;
        write_div(3);
        measure(0, n); measure(0, n); chk("R5 tx period x8 D=3", n, 32);
        dbl_speed_i = 1'b0;
    endtask

    task automatic t_master();
        int n;
        sync_sel_i = 1'b1; clk_dir_out_i = 1'b1; dbl_speed_i = 1'b0;
        write_div(2);
        @(negedge clk);
        chk("R6 oe in master", xfer_clk_oe_o, 1);
        measure(0, n); measure(0, n); chk("R6 tx period master D=2", n, 6);
        chk("R6 clock high at tx", xfer_clk_o, 1);
        @(negedge clk);
        chk("R6 clock low after fall", xfer_clk_o, 0);
        measure(1, n); chk("R6 rx period master D=2", n, 6);
        chk("R6 clock low at rx", xfer_clk_o, 0);
        @(negedge clk);
        chk("R6 clock high after rise", xfer_clk_o, 1);
    endtask

    task automatic t_master_dbl_ignored();
        int n;
        sync_sel_i = 1'b1; clk_dir_out_i = 1'b1; dbl_speed_i = 1'b1;
        write_div(3);
        measure(0, n); measure(0, n); chk("R7 speed bit ignored in sync", n, 8);
        dbl_speed_i = 1'b0;
    endtask

    task automatic t_async_pin_ignored();
        int seen = 0;
        sync_sel_i = 1'b0; clk_dir_out_i = 1'b1;
        write_div(1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i % 3 == 0) xfer_clk_pin_i = ~xfer_clk_pin_i;
            if (ext_rise_o || ext_fall_o) seen++;
        end
        chk("R8 no edges in async", seen, 0);
        chk("R8 oe low in async", xfer_clk_oe_o, 0);
        chk("R8 clock low in async", xfer_clk_o, 0);
    endtask

    task automatic t_slave_edges();
        sync_sel_i = 1'b1; clk_dir_out_i = 1'b0;
        @(negedge clk); xfer_clk_pin_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 oe low in slave", xfer_clk_oe_o, 0);
        chk("R9 clock low in slave", xfer_clk_o, 0);
        xfer_clk_pin_i = 1'b1;
        @(negedge clk); chk("R10 no rise after one edge", ext_rise_o, 0);
        @(negedge clk); chk("R10 rise after two edges", ext_rise_o, 1);
        chk("R9 rx follows rise", rx_tick_o, 1);
        chk("R9 tx idle on rise", tx_tick_o, 0);
        chk("R10 no fall with rise", ext_fall_o, 0);
        @(negedge clk); chk("R10 rise one cycle wide", ext_rise_o, 0);
        xfer_clk_pin_i = 1'b0;
        @(negedge clk); chk("R10 no fall after one edge", ext_fall_o, 0);
        @(negedge clk); chk("R10 fall after two edges", ext_fall_o, 1);
        chk("R9 tx follows fall", tx_tick_o, 1);
        chk("R9 rx idle on fall", rx_tick_o, 0);
        @(negedge clk); chk("R10 fall one cycle wide", ext_fall_o, 0);
    endtask

    initial begin
        t_reset();
        t_div_period();
        t_div_reload();
        t_async_norm();
        t_async_dbl();
        t_master();
        t_master_dbl_ignored();
        t_async_pin_ignored();
        t_slave_edges();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule